// File: doc/BRIEF.md
# Parallel Bus Master Cycle Engine

This block runs single read or write cycles on an external asynchronous parallel bus on behalf of a host that sees it as a small set of registers. A write request carries a data word and starts a write cycle; a read request starts a read cycle, and the host collects the captured word from `rd_data` once the cycle is over. The data it holds at the moment of the request is the result of the previous read. Each cycle can begin with one or two address-latch phases. These are followed by a setup phase, a strobe phase and a hold phase, and the length of each phase is programmed in clock cycles.

The host loads a 16-bit address word. Its low 14 bits are the address proper. Bit 14 and bit 15 either act as two extra address lines or enable the two chip-select lines, depending on the chip-select function. The address can be placed on its own lines, or it can share the data lines in three arrangements. After each cycle the 14-bit address can step up or down by one. The read strobe, write strobe, each chip select and the latch strobes each have their own polarity input. A busy flag covers the whole cycle, and an optional one-cycle interrupt marks its end.

Top module: `pmb_master`

## Requirements
- R1: After reset, busy and irq are low, rd_data and addr_o are zero, the data bus is not driven, and every strobe sits at its inactive level, which is the inverse of its polarity input.
- R2: The setup phase lasts cfg_setup+1 cycles (1 to 4). Data stays driven on writes and both strobes stay inactive.
- R3: The strobe phase lasts cfg_strobe+1 cycles (1 to 16). bus_rd is active during it on a read and bus_wr is active during it on a write.
- R4: The hold phase lasts cfg_hold+1 cycles on a write and cfg_hold cycles on a read. A read with cfg_hold=0 has no hold phase.
- R5: The full address is {line2 bit, line1 bit, addr[13:0]}. For cfg_mux=0 there is no latch phase and bus_addr carries addr[13:0]. For 1, one bus_al_lo phase puts the full address bits 7:0 on bus_dout[7:0], and bus_addr[13:8] carries addr[13:8]. For 2, a bus_al_lo phase with bits 7:0 is followed by a bus_al_hi phase with bits 15:8, both on bus_dout[7:0]. For 3, one bus_al_lo phase puts all 16 bits on bus_dout. Each latch phase lasts one cycle and comes before setup. In modes 1 to 3, bus_addr lines that carry no address are 0.
- R6: cfg_csfn=0 drives bus_cs2 and bus_cs1 as plain address bits from address-word bits 15 and 14. With cfg_csfn=1, bus_cs2 is a chip select enabled by bit 15 and bus_cs1 is address bit 14. With cfg_csfn of 2 or 3, both lines are chip selects, enabled by bits 15 and 14. A chip select is active only during a cycle. Address bits used as chip selects read as 0 in the full address.
- R7: Each strobe or chip select is at its polarity input value when active and at the inverse when inactive. One pol_al input serves both latch strobes.
- R8: When a cycle ends, cfg_step=1 adds one to addr[13:0] and cfg_step=2 subtracts one, wrapping at 14 bits. Codes 0 and 3 leave the address unchanged. Bits 15:14 are never changed by stepping.
- R9: With cfg_irq_en set, irq is high for exactly the one cycle after the last phase. With cfg_irq_en clear, irq stays low.
- R10: busy is high from the cycle after an accepted request through the last phase. Requests and address loads that arrive while busy have no effect. When both request inputs are high together, the write wins.
- R11: A read captures bus_din on the last strobe cycle. With cfg_wide=0, rd_data gets bus_din[7:0] zero-extended and a write drives wr_data[7:0] with the upper byte 0. rd_data changes only during a read cycle.
- R12: bus_rd and bus_wr are never active together, and the data bus is not driven while the read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_setup | input | 2 | Setup phase code |
| cfg_strobe | input | 4 | Strobe phase code |
| cfg_hold | input | 2 | Hold phase code |
| cfg_mux | input | 2 | Address/data sharing arrangement |
| cfg_csfn | input | 2 | Chip-select function |
| cfg_wide | input | 1 | 1: 16-bit data, 0: 8-bit data |
| cfg_step | input | 2 | Address step after each cycle |
| cfg_irq_en | input | 1 | Enable end-of-cycle interrupt |
| pol_rd | input | 1 | Read strobe active level |
| pol_wr | input | 1 | Write strobe active level |
| pol_cs1 | input | 1 | Chip select 1 active level |
| pol_cs2 | input | 1 | Chip select 2 active level |
| pol_al | input | 1 | Latch strobes active level |
| addr_wr | input | 1 | Load the address word |
| addr_wdata | input | 16 | Address word to load |
| addr_o | output | 16 | Current address word |
| wr_req | input | 1 | Start a write cycle |
| wr_data | input | 16 | Write data |
| rd_req | input | 1 | Start a read cycle |
| rd_data | output | 16 | Last read result |
| busy_o | output | 1 | Cycle in progress |
| irq_o | output | 1 | End-of-cycle pulse |
| bus_addr | output | 14 | Address lines |
| bus_dout | output | 16 | Data lines out |
| bus_doe | output | 1 | Data lines output enable |
| bus_din | input | 16 | Data lines in |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_al_lo | output | 1 | Address latch strobe, first/low |
| bus_al_hi | output | 1 | Address latch strobe, high byte |
| bus_cs1 | output | 1 | Chip select / address line 1 |
| bus_cs2 | output | 1 | Chip select / address line 2 |

## Verification
The bench builds the block with its default parameters: a 14-bit address, a 16-bit data path and phase fields of 2, 4 and 2 bits. This makes every phase code reachable, including the 16-cycle strobe and the read with no hold phase. It also brings the wrap of the address step at both ends of the 14-bit range within reach, as well as every pairing of sharing arrangement with chip-select function and polarity. Every cycle of every transaction is compared pin by pin with a phase list rebuilt from the codes.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
    typedef enum logic [2:0] {
        PH_IDLE, PH_LAT_LO, PH_LAT_HI, PH_SETUP, PH_STROBE, PH_HOLD
    } phase_e;

    localparam logic [1:0] MUX_NONE  = 2'd0;
    localparam logic [1:0] MUX_SPLIT = 2'd1;
    localparam logic [1:0] MUX_BYTE2 = 2'd2;
    localparam logic [1:0] MUX_FULL  = 2'd3;

    localparam logic [1:0] STEP_INC = 2'd1;
    localparam logic [1:0] STEP_DEC = 2'd2;

    localparam logic [1:0] CSF_ADDR = 2'd0;
    localparam logic [1:0] CSF_ONE  = 2'd1;

    localparam int BYTE = 8;
endpackage

// File: rtl/pmb_addr_unit.sv
module pmb_addr_unit #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W+1:0] load_val,
    input  logic              step_now,
    input  logic [1:0]        step_mode,
    output logic [ADDR_W+1:0] areg_o
);
    import pmb_pkg::*;

    typedef struct packed {
        logic              en2;
        logic              en1;
        logic [ADDR_W-1:0] addr;
    } areg_t;

    areg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d = areg_t'(load_val);
        end else if (step_now) begin
            if (step_mode == STEP_INC) s_d.addr = s_q.addr + ADDR_W'(1);
            else if (step_mode == STEP_DEC) s_d.addr = s_q.addr - ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign areg_o = s_q;
endmodule

// File: rtl/pmb_sequencer.sv
module pmb_sequencer #(
    parameter int DATA_W   = 16,
    parameter int SETUP_W  = 2,
    parameter int STROBE_W = 4,
    parameter int HOLD_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_req,
    input  logic                rd_req,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W-1:0]   din,
    input  logic [SETUP_W-1:0]  cfg_setup,
    input  logic [STROBE_W-1:0] cfg_strobe,
    input  logic [HOLD_W-1:0]   cfg_hold,
    input  logic [1:0]          cfg_mux,
    input  logic                cfg_wide,
    input  logic                cfg_irq_en,
    output pmb_pkg::phase_e     phase_o,
    output logic                is_wr_o,
    output logic [DATA_W-1:0]   wdata_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                finish_o,
    output logic                irq_o
);
    import pmb_pkg::*;

    localparam int SH_W  = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
    localparam int CNT_W = (STROBE_W > SH_W) ? STROBE_W : SH_W;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic              is_wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } seq_t;

    seq_t s_d, s_q;
    logic finish;

    function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v, input logic wide);
        return wide ? v : DATA_W'(v[BYTE-1:0]);
    endfunction

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        finish  = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (wr_req || rd_req) begin
                    s_d.is_wr = wr_req;
                    if (wr_req) s_d.wdata = fit(wr_data, cfg_wide);
                    s_d.phase = (cfg_mux == MUX_NONE) ? PH_SETUP : PH_LAT_LO;
                    s_d.cnt   = CNT_W'(cfg_setup);
                end
            end
            PH_LAT_LO: begin
                s_d.phase = (cfg_mux == MUX_BYTE2) ? PH_LAT_HI : PH_SETUP;
                s_d.cnt   = CNT_W'(cfg_setup);
            end
            PH_LAT_HI: begin
                s_d.phase = PH_SETUP;
                s_d.cnt   = CNT_W'(cfg_setup);
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = CNT_W'(cfg_strobe);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == '0) begin
                    if (s_q.is_wr) begin
                        s_d.phase = PH_HOLD;
                        s_d.cnt   = CNT_W'(cfg_hold);
                    end else begin
                        s_d.rdata = fit(din, cfg_wide);
                        if (cfg_hold == '0) begin
                            finish = 1'b1;
                        end else begin
                            s_d.phase = PH_HOLD;
                            s_d.cnt   = CNT_W'(cfg_hold) - CNT_W'(1);
                        end
                    end
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) finish = 1'b1;
                else               s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            default: s_d.phase = PH_IDLE;
        endcase
        if (finish) begin
            s_d.phase = PH_IDLE;
            s_d.irq   = cfg_irq_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign phase_o  = s_q.phase;
    assign is_wr_o  = s_q.is_wr;
    assign wdata_o  = s_q.wdata;
    assign rdata_o  = s_q.rdata;
    assign irq_o    = s_q.irq;
    assign finish_o = finish;
endmodule

// File: rtl/pmb_pin_mux.sv
module pmb_pin_mux #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16
) (
    input  pmb_pkg::phase_e   phase,
    input  logic              is_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W+1:0] areg,
    input  logic [1:0]        cfg_mux,
    input  logic [1:0]        cfg_csfn,
    input  logic              pol_rd,
    input  logic              pol_wr,
    input  logic              pol_cs1,
    input  logic              pol_cs2,
    input  logic              pol_al,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_al_lo,
    output logic              bus_al_hi,
    output logic              bus_cs1,
    output logic              bus_cs2
);
    import pmb_pkg::*;

    logic              in_cyc, data_ph, line2_addr, line1_addr;
    logic [ADDR_W+1:0] full;

    always_comb begin
        in_cyc     = (phase != PH_IDLE);
        data_ph    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        line2_addr = (cfg_csfn == CSF_ADDR);
        line1_addr = (cfg_csfn == CSF_ADDR) || (cfg_csfn == CSF_ONE);
        full       = {line2_addr & areg[ADDR_W+1], line1_addr & areg[ADDR_W],
                      areg[ADDR_W-1:0]};

        bus_addr = '0;
        case (cfg_mux)
            MUX_NONE:  bus_addr = areg[ADDR_W-1:0];
            MUX_SPLIT: bus_addr[ADDR_W-1:BYTE] = areg[ADDR_W-1:BYTE];
            default:   bus_addr = '0;
        endcase

        bus_dout = '0;
        case (phase)
            PH_LAT_LO: bus_dout = (cfg_mux == MUX_FULL) ? DATA_W'(full)
                                                        : DATA_W'(full[BYTE-1:0]);
            PH_LAT_HI: bus_dout = DATA_W'(full[2*BYTE-1:BYTE]);
            default:   if (data_ph && is_wr) bus_dout = wdata;
        endcase
        bus_doe = (phase == PH_LAT_LO) || (phase == PH_LAT_HI) || (data_ph && is_wr);

        bus_rd    = ((phase == PH_STROBE) && !is_wr) ? pol_rd : ~pol_rd;
        bus_wr    = ((phase == PH_STROBE) && is_wr)  ? pol_wr : ~pol_wr;
        bus_al_lo = (phase == PH_LAT_LO) ? pol_al : ~pol_al;
        bus_al_hi = (phase == PH_LAT_HI) ? pol_al : ~pol_al;
        bus_cs2   = line2_addr ? areg[ADDR_W+1]
                  : ((in_cyc && areg[ADDR_W+1]) ? pol_cs2 : ~pol_cs2);
        bus_cs1   = line1_addr ? areg[ADDR_W]
                  : ((in_cyc && areg[ADDR_W]) ? pol_cs1 : ~pol_cs1);
    end
endmodule

// File: rtl/pmb_master.sv
module pmb_master #(
    parameter int ADDR_W   = 14,
    parameter int DATA_W   = 16,
    parameter int SETUP_W  = 2,
    parameter int STROBE_W = 4,
    parameter int HOLD_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SETUP_W-1:0]  cfg_setup,
    input  logic [STROBE_W-1:0] cfg_strobe,
    input  logic [HOLD_W-1:0]   cfg_hold,
    input  logic [1:0]          cfg_mux,
    input  logic [1:0]          cfg_csfn,
    input  logic                cfg_wide,
    input  logic [1:0]          cfg_step,
    input  logic                cfg_irq_en,
    input  logic                pol_rd,
    input  logic                pol_wr,
    input  logic                pol_cs1,
    input  logic                pol_cs2,
    input  logic                pol_al,
    input  logic                addr_wr,
    input  logic [ADDR_W+1:0]   addr_wdata,
    output logic [ADDR_W+1:0]   addr_o,
    input  logic                wr_req,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_req,
    output logic [DATA_W-1:0]   rd_data,
    output logic                busy_o,
    output logic                irq_o,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_doe,
    input  logic [DATA_W-1:0]   bus_din,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic                bus_al_lo,
    output logic                bus_al_hi,
    output logic                bus_cs1,
    output logic                bus_cs2
);
    import pmb_pkg::*;

    phase_e            phase;
    logic              is_wr, finish;
    logic [DATA_W-1:0] wdata;

    assign busy_o = (phase != PH_IDLE);

    pmb_addr_unit #(.ADDR_W(ADDR_W)) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_wr && !busy_o),
        .load_val  (addr_wdata),
        .step_now  (finish),
        .step_mode (cfg_step),
        .areg_o    (addr_o)
    );

    pmb_sequencer #(
        .DATA_W(DATA_W), .SETUP_W(SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .rd_req     (rd_req),
        .wr_data    (wr_data),
        .din        (bus_din),
        .cfg_setup  (cfg_setup),
        .cfg_strobe (cfg_strobe),
        .cfg_hold   (cfg_hold),
        .cfg_mux    (cfg_mux),
        .cfg_wide   (cfg_wide),
        .cfg_irq_en (cfg_irq_en),
        .phase_o    (phase),
        .is_wr_o    (is_wr),
        .wdata_o    (wdata),
        .rdata_o    (rd_data),
        .finish_o   (finish),
        .irq_o      (irq_o)
    );

    pmb_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
        .phase     (phase),
        .is_wr     (is_wr),
        .wdata     (wdata),
        .areg      (addr_o),
        .cfg_mux   (cfg_mux),
        .cfg_csfn  (cfg_csfn),
        .pol_rd    (pol_rd),
        .pol_wr    (pol_wr),
        .pol_cs1   (pol_cs1),
        .pol_cs2   (pol_cs2),
        .pol_al    (pol_al),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_al_lo (bus_al_lo),
        .bus_al_hi (bus_al_hi),
        .bus_cs1   (bus_cs1),
        .bus_cs2   (bus_cs2)
    );
endmodule

// File: rtl/pmb_master_chk.sv
module pmb_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              irq_o,
    input logic              wr_req,
    input logic              rd_req,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_doe,
    input logic              bus_al_lo,
    input logic              bus_al_hi,
    input logic              pol_rd,
    input logic              pol_wr,
    input logic              pol_al,
    input logic [DATA_W-1:0] rd_data
);
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((bus_rd == pol_rd) && (bus_wr == pol_wr)));

    // R12
    read_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd == pol_rd) |-> !bus_doe);

    // R5
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((bus_al_lo == pol_al) && (bus_al_hi == pol_al)));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R9
    irq_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!busy_o && $past(busy_o)));

    // R10
    busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wr_req || rd_req));

    // R11
    rdata_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(rd_data));
endmodule

bind pmb_master pmb_master_chk #(.DATA_W(DATA_W)) i_pmb_master_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .irq_o     (irq_o),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_doe   (bus_doe),
    .bus_al_lo (bus_al_lo),
    .bus_al_hi (bus_al_hi),
    .pol_rd    (pol_rd),
    .pol_wr    (pol_wr),
    .pol_al    (pol_al),
    .rd_data   (rd_data)
);

// File: tb/test_pmb_master.sv
`timescale 1ns/1ps
module test_pmb_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_setup = '0, cfg_hold = '0, cfg_mux = '0, cfg_csfn = 2'd2, cfg_step = '0;
    logic [3:0]  cfg_strobe = '0;
    logic        cfg_wide = 1'b1, cfg_irq_en = 1'b0;
    logic        pol_rd = 0, pol_wr = 0, pol_cs1 = 0, pol_cs2 = 0, pol_al = 0;
    logic        addr_wr = 0, wr_req = 0, rd_req = 0;
    logic [15:0] addr_wdata = '0, wr_data = '0, bus_din = '0;
    logic [15:0] addr_o, rd_data, bus_dout;
    logic [13:0] bus_addr;
    logic        busy_o, irq_o, bus_doe, bus_rd, bus_wr, bus_al_lo, bus_al_hi, bus_cs1, bus_cs2;

    int total = 0;
    int bad = 0;
    logic [15:0] m_addr = '0;
    logic [15:0] m_rdata = '0;
    bit finished = 0;

    always #4 clk = ~clk;

    pmb_master i_pmb_master (.*);

    task automatic chk1(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk16(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] full_addr(logic [15:0] r, logic [1:0] csfn);
        return {(csfn == 2'd0) & r[15], (csfn <= 2'd1) & r[14], r[13:0]};
    endfunction

    function automatic logic [15:0] stepped(logic [15:0] r, logic [1:0] st);
        if (st == 2'd1) return {r[15:14], r[13:0] + 14'd1};
        if (st == 2'd2) return {r[15:14], r[13:0] - 14'd1};
        return r;
    endfunction

    // phases: 1 latch low, 2 latch high, 3 setup, 4 strobe, 5 hold
    task automatic check_phase(int p, bit is_wr, logic [15:0] wexp);
        logic [15:0] a16, e_dout;
        logic [13:0] e_pa;
        logic        e_doe;
        a16 = full_addr(m_addr, cfg_csfn);
        e_dout = '0;
        if (p == 1) e_dout = (cfg_mux == 2'd3) ? a16 : {8'h00, a16[7:0]};
        else if (p == 2) e_dout = {8'h00, a16[15:8]};
        else if (is_wr) e_dout = wexp;
        e_doe = (p <= 2) || is_wr;
        case (cfg_mux)
            2'd0: e_pa = m_addr[13:0];
            2'd1: e_pa = {m_addr[13:8], 8'h00};
            default: e_pa = '0;
        endcase
        chk1("R2 R3 R4 R7 R12 bus_rd", bus_rd, (p == 4 && !is_wr) ? pol_rd : ~pol_rd);
        chk1("R2 R3 R4 R7 R12 bus_wr", bus_wr, (p == 4 && is_wr) ? pol_wr : ~pol_wr);
        chk1("R5 R7 bus_al_lo", bus_al_lo, (p == 1) ? pol_al : ~pol_al);
        chk1("R5 R7 bus_al_hi", bus_al_hi, (p == 2) ? pol_al : ~pol_al);
        chk16("R5 R11 bus_dout", bus_dout, e_dout);
        chk1("R5 R12 bus_doe", bus_doe, e_doe);
        chk16("R5 bus_addr", 16'(bus_addr), 16'(e_pa));
        chk1("R6 R7 bus_cs2", bus_cs2, (cfg_csfn == 2'd0) ? m_addr[15]
                                      : (m_addr[15] ? pol_cs2 : ~pol_cs2));
        chk1("R6 R7 bus_cs1", bus_cs1, (cfg_csfn <= 2'd1) ? m_addr[14]
                                      : (m_addr[14] ? pol_cs1 : ~pol_cs1));
        chk1("R10 busy during cycle", busy_o, 1'b1);
    endtask

    task automatic load_addr(logic [15:0] v);
        @(negedge clk);
        addr_wr = 1'b1;
        addr_wdata = v;
        @(negedge clk);
        addr_wr = 1'b0;
        m_addr = v;
        #1 chk16("R8 address load", addr_o, v);
    endtask

    task automatic run_txn(bit is_wr, logic [15:0] data, logic [15:0] din, bit poke);
        int ph[32];
        int n = 0;
        logic [15:0] wexp;
        wexp = cfg_wide ? data : {8'h00, data[7:0]};
        if (cfg_mux != 2'd0) begin ph[n] = 1; n++; end
        if (cfg_mux == 2'd2) begin ph[n] = 2; n++; end
        for (int k = 0; k <= int'(cfg_setup); k++) begin ph[n] = 3; n++; end
        for (int k = 0; k <= int'(cfg_strobe); k++) begin ph[n] = 4; n++; end
        for (int k = 0; k < int'(cfg_hold) + (is_wr ? 1 : 0); k++) begin ph[n] = 5; n++; end
        @(negedge clk);
        bus_din = din;
        if (is_wr) begin wr_req = 1'b1; wr_data = data; end
        else rd_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        rd_req = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (poke && i == 1) begin
                // R10: requests and address load while busy are ignored
                wr_req = 1'b1; rd_req = 1'b1; wr_data = ~data;
                addr_wr = 1'b1; addr_wdata = ~m_addr;
            end
            #1 check_phase(ph[i], is_wr, wexp);
            @(negedge clk);
            wr_req = 1'b0; rd_req = 1'b0; addr_wr = 1'b0;
        end
        #1;
        if (!is_wr) m_rdata = cfg_wide ? din : {8'h00, din[7:0]};
        m_addr = stepped(m_addr, cfg_step);
        chk1("R10 busy ends after last phase", busy_o, 1'b0);
        chk1("R9 irq after cycle", irq_o, cfg_irq_en);
        chk16("R8 address step", addr_o, m_addr);
        chk16("R11 read data", rd_data, m_rdata);
        @(negedge clk);
        #1;
        chk1("R10 no cycle from ignored request", busy_o, 1'b0);
        chk1("R9 irq single cycle", irq_o, 1'b0);
        chk16("R10 address load ignored", addr_o, m_addr);
    endtask

    task automatic set_cfg(logic [1:0] su, logic [3:0] sb, logic [1:0] ho, logic [1:0] mx,
                           logic [1:0] cf, logic wd, logic [1:0] st, logic ie, logic [4:0] pl);
        @(negedge clk);
        cfg_setup = su; cfg_strobe = sb; cfg_hold = ho; cfg_mux = mx; cfg_csfn = cf;
        cfg_wide = wd; cfg_step = st; cfg_irq_en = ie;
        {pol_rd, pol_wr, pol_cs1, pol_cs2, pol_al} = pl;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h1bad5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state, all polarities active low
        chk1("R1 busy", busy_o, 1'b0);
        chk1("R1 irq", irq_o, 1'b0);
        chk16("R1 rd_data", rd_data, 16'h0000);
        chk16("R1 addr_o", addr_o, 16'h0000);
        chk1("R1 bus_doe", bus_doe, 1'b0);
        chk1("R1 bus_rd", bus_rd, 1'b1);
        chk1("R1 bus_wr", bus_wr, 1'b1);
        chk1("R1 bus_al_lo", bus_al_lo, 1'b1);
        chk1("R1 bus_al_hi", bus_al_hi, 1'b1);
        chk1("R1 bus_cs1", bus_cs1, 1'b1);
        chk1("R1 bus_cs2", bus_cs2, 1'b1);

        // shortest write, active-high strobes, separate lines
        set_cfg(2'd0, 4'd0, 2'd0, 2'd0, 2'd2, 1'b1, 2'd1, 1'b1, 5'b11111);
        load_addr(16'hC123);
        run_txn(1'b1, 16'hA55A, 16'h0000, 1'b0);
        // longest read, address lines on both selects, decrement wrap from 0
        set_cfg(2'd3, 4'd15, 2'd3, 2'd0, 2'd0, 1'b1, 2'd2, 1'b1, 5'b01010);
        load_addr(16'hC000);
        run_txn(1'b0, 16'h0000, 16'hBEEF, 1'b0);
        // read with no hold, two latch phases, one chip select, no irq
        set_cfg(2'd1, 4'd2, 2'd0, 2'd2, 2'd1, 1'b1, 2'd0, 1'b0, 5'b10101);
        load_addr(16'h8ACE);
        run_txn(1'b0, 16'h0000, 16'h1357, 1'b0);
        // narrow write, split mode, increment wrap at the top
        set_cfg(2'd2, 4'd1, 2'd1, 2'd1, 2'd2, 1'b0, 2'd1, 1'b1, 5'b00000);
        load_addr(16'h7FFF);
        run_txn(1'b1, 16'hFFC3, 16'h0000, 1'b0);
        // narrow read, full-width latch, requests poked while busy
        set_cfg(2'd0, 4'd3, 2'd2, 2'd3, 2'd3, 1'b0, 2'd3, 1'b1, 5'b11000);
        run_txn(1'b0, 16'h0000, 16'h9A7E, 1'b1);
        run_txn(1'b1, 16'h2468, 16'h0000, 1'b1);

        for (int t = 0; t < 90; t++) begin
            set_cfg(2'($urandom), 4'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                    1'($urandom), 2'($urandom), 1'($urandom), 5'($urandom));
            if ($urandom_range(0, 4) == 0) load_addr(16'($urandom));
            run_txn(1'($urandom), 16'($urandom), 16'($urandom), $urandom_range(0, 3) == 0);
        end
        finish_run();
    end
endmodule